// File: doc/BRIEF.md
# Two-phase latch scan chain with phase sequencer

This block is a register of shift-register latch cells. Each cell holds a pair of level-sensitive, polarity-hold latches. The first latch, called the master, has two data ports. It captures the functional input while the system phase is high. It captures the serial input while the first shift phase is high. The second latch, called the slave, copies the master while the second shift phase is high. The cells are linked in series: each slave feeds the serial port of the next master, and the last slave drives the serial output. The master contents are the functional outputs.

A small synchronous sequencer makes every latch clock from one free-running reference clock. Asking for a shift of K steps produces K rounds of a master-shift phase followed by a slave-shift phase. The two phases never overlap, and an all-low cycle stands between any two pulses. Asking for a capture produces one system pulse, which loads every master from the parallel input, and then one slave phase, which moves the loaded word into the scan path so that it can be unloaded. When the sequencer is idle, all three latch clocks stay low and every latch holds its value.

Top module: `lssd_scan_chain`

## Requirements
- R1: A capture request taken while idle gives exactly one system-phase cycle, followed by an all-low cycle and one slave-phase cycle, and no master-shift cycle. Afterwards `sys_q` equals the `sys_d` value held during the request, and `scan_out` equals bit WIDTH-1 of that value.
- R2: Each shift step loads master 0 from `scan_in` and master i from slave i-1, and then copies every master into its slave. After the step, `sys_q` equals the previous slave word shifted up by one, with `scan_in` at bit 0.
- R3: The slave phase is never high in the same cycle as the master-shift phase or the system phase, and the system and master-shift phases are never high together.
- R4: Each phase pulse lasts one cycle, and the cycle after any pulse has all three phases low.
- R5: When the system and master-shift phases are low, `sys_q` holds its value whatever `sys_d` and `scan_in` do. When the slave phase is low, `scan_out` holds.
- R6: After synchronous active-low reset, and whenever `busy` is low, all three phases are low.
- R7: A shift request of K>0 steps gives exactly K master-shift and K slave-shift pulses, keeps `busy` high for 4*K cycles and then returns to idle. A request with K=0 is ignored.
- R8: Requests are taken only while idle. Requests that arrive while `busy` is high are ignored. If a shift request with K>0 and a capture request arrive in the same idle cycle, the shift runs and the capture is dropped.
- R9: `scan_out` is the slave output of the last cell, WIDTH-1. After WIDTH shift steps it shows the first bit shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for the sequencer |
| rst_n | input | 1 | Synchronous active-low reset of the sequencer |
| shift_req | input | 1 | Request a shift of `shift_steps` steps |
| shift_steps | input | STEP_W | Number of shift steps to perform |
| capture_req | input | 1 | Request a parallel capture of `sys_d` |
| sys_d | input | WIDTH | Functional data for the master latches |
| scan_in | input | 1 | Serial input into master 0 |
| sys_q | output | WIDTH | Master latch contents |
| scan_out | output | 1 | Slave output of the last cell |
| ph_a | output | 1 | Master-shift phase |
| ph_b | output | 1 | Slave-shift phase |
| ph_c | output | 1 | System phase |
| busy | output | 1 | Sequence in progress |

## Verification
A shift request and a capture request can reach the idle sequencer in the same cycle, and both would drive the master latches. The bench raises both at once with a nonzero step count. It then counts the pulses on each phase: a correct design shows no system pulse and exactly K shift pairs, and the master word must match a shift-only model. A second scenario raises both requests in the middle of a running shift, and the pulse counts must stay those of the first request.

// File: rtl/lssd_pkg.sv
`timescale 1ns/1ps
// Shared types for the two-phase latch scan chain.
package lssd_pkg;

    // Sequencer states. PG_IDLE must stay at the all-zero encoding.
    typedef enum logic [2:0] {
        PG_IDLE    = 3'd0,
        PG_SH_A    = 3'd1,
        PG_SH_GAP1 = 3'd2,
        PG_SH_B    = 3'd3,
        PG_SH_GAP2 = 3'd4,
        PG_CAP_C   = 3'd5,
        PG_CAP_GAP = 3'd6,
        PG_CAP_B   = 3'd7
    } pg_state_e;

endpackage

// File: rtl/lssd_phase_gen.sv
`timescale 1ns/1ps
// Phase sequencer.
// Turns shift and capture requests into one-cycle pulses on three latch
// clocks, with an all-low cycle after every pulse.
// Assumes: requests are sampled only in idle, and the phases are decoded
// from one state register so that no two can be high together.
module lssd_phase_gen
    import lssd_pkg::*;
#(
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_req,
    input  logic [STEP_W-1:0] shift_steps,
    input  logic              capture_req,
    output logic              ph_a,
    output logic              ph_b,
    output logic              ph_c,
    output logic              busy
);

    localparam logic [STEP_W-1:0] STEP_ONE  = STEP_W'(1);
    localparam logic [STEP_W-1:0] STEP_ZERO = '0;

    pg_state_e         state_q, state_d;
    logic [STEP_W-1:0] remain_q, remain_d;
    logic              shift_go;

    // A shift request counts only with a nonzero step count.
    assign shift_go = shift_req && (shift_steps != STEP_ZERO);

    // Next-state and step-count logic.
    always_comb begin
        state_d  = state_q;
        remain_d = remain_q;
        unique case (state_q)
            PG_IDLE: begin
                if (shift_go) begin
                    state_d  = PG_SH_A;
                    remain_d = shift_steps;
                end else if (capture_req) begin
                    state_d = PG_CAP_C;
                end
            end
            PG_SH_A:    state_d = PG_SH_GAP1;
            PG_SH_GAP1: state_d = PG_SH_B;
            PG_SH_B: begin
                state_d  = PG_SH_GAP2;
                remain_d = remain_q - STEP_ONE;
            end
            PG_SH_GAP2: state_d = (remain_q == STEP_ZERO) ? PG_IDLE : PG_SH_A;
            PG_CAP_C:   state_d = PG_CAP_GAP;
            PG_CAP_GAP: state_d = PG_CAP_B;
            PG_CAP_B:   state_d = PG_IDLE;
            default:    state_d = PG_IDLE;
        endcase
    end

    // State and counter registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= PG_IDLE;
            remain_q <= STEP_ZERO;
        end else begin
            state_q  <= state_d;
            remain_q <= remain_d;
        end
    end

    // Phase decode from the state register only.
    always_comb begin
        ph_a = (state_q == PG_SH_A);
        ph_b = (state_q == PG_SH_B) || (state_q == PG_CAP_B);
        ph_c = (state_q == PG_CAP_C);
        busy = (state_q != PG_IDLE);
    end

endmodule

// File: rtl/lssd_srl.sv
`timescale 1ns/1ps
// One shift-register latch cell.
// The master is transparent to sys_d while ph_c is high and to scan_d while
// ph_a is high. The slave is transparent to the master while ph_b is high.
// Assumes: ph_b never overlaps ph_a or ph_c, so no path through the cell is
// transparent from end to end.
module lssd_srl (
    input  logic ph_a,
    input  logic ph_b,
    input  logic ph_c,
    input  logic sys_d,
    input  logic scan_d,
    output logic mst_q,
    output logic slv_q
);

    // Master latch with two ports; the system port wins if both are open.
    always_latch begin
        if (ph_c) begin
            mst_q <= sys_d;
        end else if (ph_a) begin
            mst_q <= scan_d;
        end
    end

    // Slave latch copies the master.
    always_latch begin
        if (ph_b) begin
            slv_q <= mst_q;
        end
    end

endmodule

// File: rtl/lssd_chain.sv
`timescale 1ns/1ps
// Serial chain of WIDTH latch cells.
// Cell 0 takes scan_in; cell i takes the slave of cell i-1; the slave of
// the last cell is scan_out.
// Assumes: the phases come from lssd_phase_gen.
module lssd_chain #(
    parameter int WIDTH = 8
) (
    input  logic             ph_a,
    input  logic             ph_b,
    input  logic             ph_c,
    input  logic [WIDTH-1:0] sys_d,
    input  logic             scan_in,
    output logic [WIDTH-1:0] sys_q,
    output logic             scan_out
);

    localparam int LINKS = WIDTH + 1;

    logic [LINKS-1:0] link;

    // Serial entry point of the chain.
    assign link[0] = scan_in;

    // One cell per bit, each slave feeding the next serial port.
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_cell
        lssd_srl u_srl (
            .ph_a   (ph_a),
            .ph_b   (ph_b),
            .ph_c   (ph_c),
            .sys_d  (sys_d[gi]),
            .scan_d (link[gi]),
            .mst_q  (sys_q[gi]),
            .slv_q  (link[gi+1])
        );
    end

    // Serial exit point.
    assign scan_out = link[LINKS-1];

endmodule

// File: rtl/lssd_scan_chain.sv
`timescale 1ns/1ps
// Top level: phase sequencer plus latch chain.
// Assumes: clk runs freely and rst_n is synchronous and active low. The
// latches themselves are not reset and are set up by a capture or a shift.
module lssd_scan_chain #(
    parameter int WIDTH  = 8,
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_req,
    input  logic [STEP_W-1:0] shift_steps,
    input  logic              capture_req,
    input  logic [WIDTH-1:0]  sys_d,
    input  logic              scan_in,
    output logic [WIDTH-1:0]  sys_q,
    output logic              scan_out,
    output logic              ph_a,
    output logic              ph_b,
    output logic              ph_c,
    output logic              busy
);

    // Latch clock sequencer.
    lssd_phase_gen #(.STEP_W(STEP_W)) u_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .shift_req   (shift_req),
        .shift_steps (shift_steps),
        .capture_req (capture_req),
        .ph_a        (ph_a),
        .ph_b        (ph_b),
        .ph_c        (ph_c),
        .busy        (busy)
    );

    // Latch chain.
    lssd_chain #(.WIDTH(WIDTH)) u_chain (
        .ph_a     (ph_a),
        .ph_b     (ph_b),
        .ph_c     (ph_c),
        .sys_d    (sys_d),
        .scan_in  (scan_in),
        .sys_q    (sys_q),
        .scan_out (scan_out)
    );

endmodule

// File: rtl/lssd_scan_chain_chk.sv
`timescale 1ns/1ps
// Property checker for lssd_scan_chain, attached with bind.
module lssd_scan_chain_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ph_a,
    input logic             ph_b,
    input logic             ph_c,
    input logic             busy,
    input logic             scan_out,
    input logic [WIDTH-1:0] sys_q
);

    a_r3_ab_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(ph_a && ph_b));

    a_r3_cb_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(ph_c && ph_b));

    a_r3_ca_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(ph_c && ph_a));

    a_r4_gap_after_a: assert property (@(posedge clk) disable iff (!rst_n)
        ph_a |=> !(ph_a || ph_b || ph_c));

    a_r4_gap_after_b: assert property (@(posedge clk) disable iff (!rst_n)
        ph_b |=> !(ph_a || ph_b || ph_c));

    a_r4_gap_after_c: assert property (@(posedge clk) disable iff (!rst_n)
        ph_c |=> !(ph_a || ph_b || ph_c));

    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(ph_a || ph_b || ph_c));

    a_r5_master_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(ph_a || ph_c) |-> $stable(sys_q));

    a_r9_slave_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ph_b |-> $stable(scan_out));

endmodule

bind lssd_scan_chain lssd_scan_chain_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ph_a     (ph_a),
    .ph_b     (ph_b),
    .ph_c     (ph_c),
    .busy     (busy),
    .scan_out (scan_out),
    .sys_q    (sys_q)
);

// File: tb/lssd_scan_chain_tb_top.sv
`timescale 1ns/1ps
// Directed bench for lssd_scan_chain.
module lssd_scan_chain_tb_top;

    localparam int W  = 8;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          shift_req = 1'b0;
    logic [SW-1:0] shift_steps = '0;
    logic          capture_req = 1'b0;
    logic [W-1:0]  sys_d = '0;
    logic          scan_in = 1'b0;
    logic [W-1:0]  sys_q;
    logic          scan_out, ph_a, ph_b, ph_c, busy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Phase monitor counters.
    int cnt_a, cnt_b, cnt_c, cnt_busy, viol;
    logic prev_a = 1'b0, prev_b = 1'b0, prev_c = 1'b0;

    // Model of the latch contents.
    logic [W-1:0] m_mst, m_slv;

    lssd_scan_chain #(.WIDTH(W), .STEP_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .shift_req(shift_req),
        .shift_steps(shift_steps), .capture_req(capture_req),
        .sys_d(sys_d), .scan_in(scan_in), .sys_q(sys_q),
        .scan_out(scan_out), .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c),
        .busy(busy)
    );

    always #10 clk = ~clk;

    // Count pulses and flag overlap or missing gaps at each falling edge.
    always @(negedge clk) begin
        if (ph_a) cnt_a++;
        if (ph_b) cnt_b++;
        if (ph_c) cnt_c++;
        if (busy) cnt_busy++;
        if ((ph_a && ph_b) || (ph_b && ph_c) || (ph_a && ph_c)) viol++;
        if ((prev_a || prev_b || prev_c) && (ph_a || ph_b || ph_c)) viol++;
        if (!busy && (ph_a || ph_b || ph_c)) viol++;
        prev_a = ph_a; prev_b = ph_b; prev_c = ph_c;
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr_counts();
        cnt_a = 0; cnt_b = 0; cnt_c = 0; cnt_busy = 0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // R6: reset state.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy, "R6 busy after reset", busy, 0);
        chk(!(ph_a || ph_b || ph_c), "R6 phases after reset",
            {ph_a, ph_b, ph_c}, 0);
        rst_n = 1'b1;
        clr_counts();
        repeat (3) @(negedge clk);
        chk(cnt_a + cnt_b + cnt_c == 0, "R6 no pulses while idle",
            cnt_a + cnt_b + cnt_c, 0);
    endtask

    // R1: parallel capture.
    task automatic t_capture(input logic [W-1:0] pat);
        clr_counts();
        sys_d = pat;
        capture_req = 1'b1;
        @(negedge clk);
        capture_req = 1'b0;
        wait_idle();
        m_mst = pat; m_slv = pat;
        chk(sys_q == pat, "R1 capture sys_q", sys_q, pat);
        chk(scan_out == pat[W-1], "R1 capture scan_out", scan_out, pat[W-1]);
        chk(cnt_c == 1 && cnt_b == 1 && cnt_a == 0, "R1 capture pulses",
            {cnt_a[7:0], cnt_b[7:0], cnt_c[7:0]}, 32'h000101);
        chk(cnt_busy == 3, "R1 capture busy length", cnt_busy, 3);
    endtask

    // R2 R7 R9: shift of k steps, bit s of bits entering on step s.
    task automatic t_shift(input int k, input logic [63:0] bits,
                           input bit with_cap, input bit poke_busy);
        clr_counts();
        viol = 0;
        scan_in = bits[0];
        shift_steps = SW'(k);
        shift_req = 1'b1;
        capture_req = with_cap;
        @(negedge clk);
        shift_req = 1'b0;
        capture_req = 1'b0;
        for (int s = 0; s < k; s++) begin
            while (!ph_b) @(negedge clk);
            if (poke_busy && s == 0) begin
                capture_req = 1'b1;
                shift_req = 1'b1;
                shift_steps = SW'(5);
            end
            scan_in = (s + 1 < 64) ? bits[s+1] : 1'b0;
            @(negedge clk);
            capture_req = 1'b0;
            shift_req = 1'b0;
        end
        wait_idle();
        for (int s = 0; s < k; s++) begin
            m_mst = {m_slv[W-2:0], bits[s]};
            m_slv = m_mst;
        end
        chk(sys_q == m_mst, "R2 shifted word", sys_q, m_mst);
        chk(scan_out == m_slv[W-1], "R9 scan_out last slave",
            scan_out, m_slv[W-1]);
        chk(cnt_a == k && cnt_b == k, "R7 pulse pairs",
            {cnt_a[15:0], cnt_b[15:0]}, {k[15:0], k[15:0]});
        chk(cnt_busy == 4 * k, "R7 busy length", cnt_busy, 4 * k);
        chk(cnt_c == 0, "R8 no system pulse in shift", cnt_c, 0);
        chk(viol == 0, "R3 R4 overlap or gap", viol, 0);
    endtask

    // R5: inputs move while idle; latches hold.
    task automatic t_hold();
        logic [W-1:0] q0;
        logic         s0;
        q0 = sys_q;
        s0 = scan_out;
        for (int i = 0; i < 6; i++) begin
            sys_d = ~sys_d ^ W'(i);
            scan_in = ~scan_in;
            @(negedge clk);
            chk(sys_q == q0, "R5 sys_q holds", sys_q, q0);
            chk(scan_out == s0, "R5 scan_out holds", scan_out, s0);
        end
    endtask

    // R7: zero-step request ignored.
    task automatic t_zero();
        logic [W-1:0] q0;
        q0 = sys_q;
        clr_counts();
        shift_steps = '0;
        shift_req = 1'b1;
        @(negedge clk);
        shift_req = 1'b0;
        repeat (4) @(negedge clk);
        chk(cnt_busy == 0 && cnt_a == 0 && cnt_b == 0, "R7 zero steps ignored",
            cnt_busy + cnt_a + cnt_b, 0);
        chk(sys_q == q0, "R7 zero steps leave data", sys_q, q0);
    endtask

    initial begin
        t_reset();
        t_capture(8'hA5);
        t_hold();
        t_capture(8'h3C);
        t_shift(1, 64'h1, 1'b0, 1'b0);
        t_shift(3, 64'h5, 1'b0, 1'b0);
        t_shift(W, 64'hB4, 1'b0, 1'b0);
        t_zero();
        // R8: shift and capture in the same idle cycle.
        t_capture(8'hFF);
        t_shift(2, 64'h0, 1'b1, 1'b0);
        // R8: requests during a running shift are ignored.
        t_shift(3, 64'h6, 1'b0, 1'b1);
        t_shift(10, 64'h2D3, 1'b0, 1'b0);
        t_hold();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_chk, n_fail);
            $finish;
        end
    end

endmodule